// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers up to 29 level-sensitive peripheral interrupt requests into a 32-bit cause register. It gates them with a 32-bit enable register and raises a single CPU interrupt line. Each request line sets its own cause bit and holds it until software clears it. Software clears a bit by writing a zero into that position of the cause register. Writing a one into a position leaves that bit as it was, so a read-modify-write that drops one bit acknowledges exactly one source.

Three positions of the cause register have no storage. They are summaries that the hardware derives from the stored bits:

- Position 0 reports whether anything at all is latched.
- Position 30 covers positions 1 to 20 together with 26 to 29.
- Position 31 covers positions 1 to 25.

The block also reports the lowest-numbered source that is both latched and enabled, together with a valid flag. When the CPU reads the cause register while nothing is both latched and enabled, the block pulses a spurious flag so that dispatch code can count an unexplained interrupt.

Access uses a single-cycle register port with address, write enable, read enable and 32-bit data. Read data is registered.

Top module: `irq_cause_mask_ctrl`

## Requirements
- R1: After a synchronous reset, the cause and enable registers read as zero, and `cpu_irq_o`, `pick_valid_o`, `pick_idx_o` and `spurious_o` are all 0.
- R2: When `irq_src_i[k]` is high at a clock edge, cause position k+1 reads as 1 from that edge onward. The bit stays set after the request drops, until software clears it.
- R3: A write of `reg_wdata_i` to offset 0 clears every stored cause position whose data bit is 0. Positions whose data bit is 1 keep their value.
- R4: If a request is high in the same cycle as a write that would clear its cause position, the position stays set.
- R5: Writes to cause positions 0, 30 and 31 have no effect. Those positions always read as their summaries.
- R6: Cause position 0 reads as the OR of stored positions 1 to 29.
- R7: Cause position 30 reads as the OR of stored positions 26 to 29 and 1 to 20.
- R8: Cause position 31 reads as the OR of stored positions 1 to 25.
- R9: The enable register at offset 4 is a plain 32-bit read/write register, where a 1 enables the source at that position. `cpu_irq_o` is high one cycle after any position from 1 to 29 is both set in the cause register and set in the enable register.
- R10: `pick_valid_o` follows `cpu_irq_o`. While it is high, `pick_idx_o` holds the lowest position from 1 to 29 that is both latched and enabled.
- R11: A read of offset 0 made while no position is both latched and enabled raises `spurious_o` for exactly one cycle, in the cycle the read data appears. At all other times `spurious_o` is 0.
- R12: An address other than 0 or 4 returns zero on a read, and a write to it changes neither register.
- R13: Read data appears on `reg_rdata_o` in the cycle after the read and holds until the next read. When a write and a read hit the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | NUM_SRC (29) | Level requests; bit k feeds cause position k+1 |
| reg_addr_i | input | ADDR_W (8) | Byte offset: 0 selects cause, 4 selects enable |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| cpu_irq_o | output | 1 | CPU interrupt line |
| pick_idx_o | output | IDX_W (5) | Lowest pending enabled position |
| pick_valid_o | output | 1 | `pick_idx_o` is meaningful |
| spurious_o | output | 1 | Cause read found nothing pending and enabled |

## Verification
A request or a cause write takes effect at the next edge, so a read issued in the following cycle returns the new value one edge later. `cpu_irq_o`, `pick_idx_o` and `pick_valid_o` lag the cause and enable state by one register, which puts them two edges after the request that caused them. The bench drives inputs on the falling edge and steps a behavioural model at each rising edge, computing every registered output from the state before that edge. It then compares all outputs on the next falling edge, and it also runs directed scenarios whose expected words are written out in full.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned SRC_LO = 1;
  localparam int unsigned SRC_HI = 29;

  // contiguous run of ones from position lo up to position hi
  function automatic logic [REG_W-1:0] span(input int unsigned hi, input int unsigned lo);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < REG_W; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_NONE = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irqc_cause_bank.sv
module irqc_cause_bank #(
  parameter int unsigned NUM_SRC = 29
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wr_keep_i,
  output logic [NUM_SRC-1:0] cause_o
);
  logic [NUM_SRC-1:0] cause_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic keep;
    assign keep = wr_en_i ? (cause_q[g] & wr_keep_i[g]) : cause_q[g];
    always_ff @(posedge clk) begin
      if (rst) cause_q[g] <= 1'b0;
      else     cause_q[g] <= keep | src_i[g];
    end
  end

  assign cause_o = cause_q;

  AST_SRC_SETS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((cause_q & $past(src_i)) == $past(src_i))); // R4

  AST_NO_FALSE_SET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((cause_q & ~$past(cause_q) & ~$past(src_i)) == '0)); // R2

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr_en_i) |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R3
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 29,
  parameter int unsigned A_UP_LO  = 26,
  parameter int unsigned A_LOW_HI = 20,
  parameter int unsigned B_HI     = 25
) (
  input  logic [NUM_SRC-1:0] cause_i,
  output logic [REG_W-1:0]   view_o
);
  localparam logic [REG_W-1:0] ALL_MASK = span(NUM_SRC, 1);
  localparam logic [REG_W-1:0] A_MASK   = span(NUM_SRC, A_UP_LO) | span(A_LOW_HI, 1);
  localparam logic [REG_W-1:0] B_MASK   = span(B_HI, 1);

  logic [REG_W-1:0] full;
  logic any_set, grp_a, grp_b;

  always_comb begin
    full = '0;
    full[NUM_SRC:1] = cause_i;
    any_set = |(full & ALL_MASK);
    grp_a   = |(full & A_MASK);
    grp_b   = |(full & B_MASK);
    view_o  = full;
    view_o[0]         = any_set;
    view_o[REG_W-2]   = grp_a;
    view_o[REG_W-1]   = grp_b;
  end
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int unsigned NUM_SRC = 29,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pend_i[k]) begin
        idx_o   = IDX_W'(k + 1);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_cause_mask_ctrl.sv
module irq_cause_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 29,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CAUSE_OFS = 0,
  parameter int unsigned MASK_OFS  = 4,
  parameter int unsigned IDX_W     = $clog2(REG_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               cpu_irq_o,
  output logic [IDX_W-1:0]   pick_idx_o,
  output logic               pick_valid_o,
  output logic               spurious_o
);
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] cause;
  logic [REG_W-1:0]   cause_view;
  logic [REG_W-1:0]   mask_q;
  logic [NUM_SRC-1:0] pend;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_found;
  logic [REG_W-1:0]   rd_mux;
  logic               irq_q, valid_q, spur_q;
  logic [IDX_W-1:0]   idx_q;
  logic [REG_W-1:0]   rdata_q;

  always_comb begin
    if (reg_addr_i == ADDR_W'(CAUSE_OFS))     sel = SEL_CAUSE;
    else if (reg_addr_i == ADDR_W'(MASK_OFS)) sel = SEL_ENABLE;
    else                                      sel = SEL_NONE;
  end

  irqc_cause_bank #(.NUM_SRC(NUM_SRC)) i_bank (
    .clk       (clk),
    .rst       (rst),
    .src_i     (irq_src_i),
    .wr_en_i   (reg_we_i && sel == SEL_CAUSE),
    .wr_keep_i (reg_wdata_i[NUM_SRC:1]),
    .cause_o   (cause)
  );

  irqc_summary #(.NUM_SRC(NUM_SRC)) i_sum (
    .cause_i (cause),
    .view_o  (cause_view)
  );

  always_ff @(posedge clk) begin
    if (rst)                                mask_q <= '0;
    else if (reg_we_i && sel == SEL_ENABLE) mask_q <= reg_wdata_i;
  end

  assign pend = cause & mask_q[NUM_SRC:1];

  irqc_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_pick (
    .pend_i  (pend),
    .idx_o   (pick_idx),
    .found_o (pick_found)
  );

  always_comb begin
    case (sel)
      SEL_CAUSE:  rd_mux = cause_view;
      SEL_ENABLE: rd_mux = mask_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
      spur_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q   <= |pend;
      valid_q <= pick_found;
      idx_q   <= pick_found ? pick_idx : '0;
      spur_q  <= reg_re_i && sel == SEL_CAUSE && !pick_found;
      if (reg_re_i) rdata_q <= rd_mux;
    end
  end

  assign cpu_irq_o    = irq_q;
  assign pick_valid_o = valid_q;
  assign pick_idx_o   = idx_q;
  assign spurious_o   = spur_q;
  assign reg_rdata_o  = rdata_q;

  AST_VALID_IRQ: assert property (@(posedge clk) disable iff (rst)
    valid_q == irq_q); // R10

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (idx_q >= IDX_W'(1) && idx_q <= IDX_W'(NUM_SRC))); // R10

  AST_IDX_PENDING: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ((($past(pend) >> (idx_q - IDX_W'(1))) & NUM_SRC'(1)) != '0)); // R10

  AST_SPUR_EXCL: assert property (@(posedge clk) disable iff (rst)
    spur_q |-> !irq_q); // R11

  AST_SUMMARY_UNION: assert property (@(posedge clk) disable iff (rst)
    cause_view[0] == (cause_view[REG_W-2] | cause_view[REG_W-1])); // R6
endmodule

// File: tb/test_irq_cause_mask_ctrl.sv
`timescale 1ns/1ps
module test_irq_cause_mask_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [28:0] src = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, valid, spur;
  logic [4:0]  idx;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_cause_mask_ctrl i_irq_cause_mask_ctrl (
    .clk(clk), .rst(rst), .irq_src_i(src), .reg_addr_i(addr),
    .reg_we_i(we), .reg_re_i(re), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_irq_o(irq), .pick_idx_o(idx), .pick_valid_o(valid), .spurious_o(spur)
  );

  // behavioural reference model
  bit [31:0] m_cause, m_mask, e_rdata;
  bit        e_irq, e_valid, e_spur;
  int        e_idx;

  function automatic bit [31:0] view(bit [31:0] c);
    bit [31:0] v;
    v = c;
    v[0]  = |c[29:1];
    v[30] = |{c[29:26], c[20:1]};
    v[31] = |c[25:1];
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cause = 0; m_mask = 0; e_rdata = 0;
      e_irq = 0; e_valid = 0; e_spur = 0; e_idx = 0;
    end else begin
      int low;
      low = 0;
      for (int i = 29; i >= 1; i--) if (m_cause[i] && m_mask[i]) low = i;
      e_irq = (low != 0);
      e_valid = (low != 0);
      e_idx = low;
      e_spur = re && addr == 0 && low == 0;
      if (re) e_rdata = (addr == 0) ? view(m_cause) : (addr == 4) ? m_mask : 0;
      for (int i = 1; i <= 29; i++) begin
        if (we && addr == 0) m_cause[i] = (m_cause[i] & wdata[i]) | src[i-1];
        else                 m_cause[i] = m_cause[i] | src[i-1];
      end
      if (we && addr == 4) m_mask = wdata;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(irq == e_irq, "R9 model cpu_irq", 32'(irq), 32'(e_irq));
    chk(valid == e_valid, "R10 model valid", 32'(valid), 32'(e_valid));
    chk(idx == 5'(e_idx), "R10 model idx", 32'(idx), 32'(e_idx));
    chk(spur == e_spur, "R11 model spurious", 32'(spur), 32'(e_spur));
    chk(rdata == e_rdata, "R13 model rdata", rdata, e_rdata);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1; tick(); we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; re = 1; tick(); re = 0; d = rdata;
  endtask

  task automatic pulse(logic [28:0] s);
    src = s; tick(); src = '0;
  endtask

  task automatic clear_all(); wr(0, 32'h0); endtask

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    chk(irq == 0 && valid == 0 && idx == 0 && spur == 0, "R1 outputs after reset",
        {irq, valid, spur, idx}, 0);
    rst = 0; tick();
    rd(0, d); chk(d == 0, "R1 cause reset", d, 0);
    rd(4, d); chk(d == 0, "R1 mask reset", d, 0);

    // R2, R6, R7, R8: one-cycle pulse on source feeding position 5
    pulse(29'(1) << 4);
    tick();
    rd(0, d); chk(d == 32'hC000_0021, "R2 latched after pulse", d, 32'hC000_0021);
    chk(d[0] == 1, "R6 any bit", d, 32'hC000_0021);
    chk(irq == 0, "R9 masked source no irq", 32'(irq), 0);
    wr(4, 32'h20); tick();
    chk(irq == 1 && valid && idx == 5, "R9 enabled irq", {irq, valid, idx}, {2'b11, 5'd5});

    // R3: write-zero clears, write-one keeps
    wr(0, 32'hFFFF_FFDF); tick();
    rd(0, d); chk(d == 0, "R3 clear single", d, 0);
    pulse((29'(1) << 2) | (29'(1) << 6)); tick();
    wr(0, ~(32'h8)); tick();
    rd(0, d); chk(d == 32'hC000_0081, "R3 keep others", d, 32'hC000_0081);

    // R4: set beats clear
    addr = 0; wdata = 0; we = 1; src = 29'(1) << 8; tick(); we = 0; src = '0;
    rd(0, d); chk(d == 32'hC000_0201, "R4 set wins", d, 32'hC000_0201);

    // R7, R8 irregular groups
    clear_all(); pulse(29'(1) << 26); tick();
    rd(0, d); chk(d == 32'h4800_0001, "R7 group upper", d, 32'h4800_0001);
    clear_all(); pulse(29'(1) << 21); tick();
    rd(0, d); chk(d == 32'h8040_0001, "R8 group mid", d, 32'h8040_0001);

    // R5: writes to summary positions ignored
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk(d == 32'h8040_0001, "R5 write ones no effect", d, 32'h8040_0001);
    clear_all(); wr(0, 32'hC000_0001);
    rd(0, d); chk(d == 0, "R5 summary write no set", d, 0);

    // R10 priority
    wr(4, 32'hFFFF_FFFF);
    pulse((29'(1) << 11) | (29'(1) << 2) | (29'(1) << 28)); tick(); tick();
    chk(valid && idx == 3, "R10 lowest wins", 32'(idx), 3);
    wr(0, ~32'h8); tick();
    chk(valid && idx == 12, "R10 next lowest", 32'(idx), 12);

    // R11 spurious
    wr(4, 32'h0); tick();
    rd(0, d); chk(spur == 1, "R11 spurious on read", 32'(spur), 1);
    tick(); chk(spur == 0, "R11 one cycle", 32'(spur), 0);
    wr(4, 32'h1000); tick();
    rd(0, d); chk(spur == 0, "R11 no spurious when pending", 32'(spur), 0);

    // R12 unmapped address
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk(d == 0, "R12 unmapped reads zero", d, 0);
    rd(4, d); chk(d == 32'h1000, "R12 mask untouched", d, 32'h1000);

    // R13 same-cycle write and read
    addr = 4; wdata = 32'h0000_0F00; we = 1; re = 1; tick(); we = 0; re = 0;
    chk(rdata == 32'h1000, "R13 read before write", rdata, 32'h1000);
    tick(); chk(rdata == 32'h1000, "R13 rdata holds", rdata, 32'h1000);
    rd(4, d); chk(d == 32'h0F00, "R13 new value", d, 32'h0F00);

    repeat (4) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule